// File: doc/BRIEF.md
# Motor Stall Detector with Inrush Blanking

This block decides when a brushed DC motor has stalled. A comparator outside the block raises a single bit whenever the sensed motor current is at or above the trip reference. The block brings that bit into its clock domain and ignores it during a programmable startup window, so that inrush current is not mistaken for a stall. After the window closes, the first high sample counts as a stall.

A detected stall sets a status flag. One mode also raises a latched request to switch the bridge outputs off. The other mode only indicates the stall and leaves the outputs running. Either way, only an explicit clear-fault strobe removes the flag, and that strobe also opens a new startup window. An active-low fault pin can mirror the flag when reporting is enabled.

The startup window lasts a fixed offset plus a 16-bit setting times a step. Both the offset and the step are clock-cycle parameters, with defaults for a 100 MHz clock (5 ms offset, 102.4 µs step). The window reopens on reset (power-up), on a power-up strobe, on fault recovery, on sleep exit and on a clear-fault strobe. A 16-bit setting of 25F5h gives about 1 s at the default parameters.

Top module: `stall_detector`

## Requirements
- R1: The comparator input passes through two flip-flops. Outside the window, with detection enabled and no stall flagged, the stall flag rises on the third rising clock edge after the comparator input goes high.
- R2: The blanking window lasts OFF_CYC + T*STEP_CYC clock cycles, where T is the 16-bit setting captured when the window starts. `blank_o` is 1 for exactly those cycles, and T = 0 gives the offset alone.
- R3: Synchronous reset, the power-up, fault-recovery and sleep-exit strobes, and the clear-fault strobe each restart the window from its full length, even when a window is already running.
- R4: With `det_en_i` = 0, the stall flag is never set and the output-disable request never rises.
- R5: With `smode_i` = 0, a detected stall sets both the stall flag and `out_dis_o`. `out_dis_o` then stays 1 until a clear-fault strobe.
- R6: With `smode_i` = 1, a detected stall sets the stall flag and leaves `out_dis_o` at 0.
- R7: A clear-fault strobe returns both the stall flag and `out_dis_o` to 0 on the next edge. If current is still above trip when the new window ends, the stall is detected again.
- R8: `fault_n_o` is 0 exactly when the stall flag is 1 and `rep_en_i` is 1. With `rep_en_i` = 0, `fault_n_o` stays 1.
- R9: When a clear-fault strobe falls in the same cycle as a stall qualification, the clear wins: the flag stays 0 and the window restarts.
- R10: While `blank_o` is 1, the stall flag is never set, whatever the comparator input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; acts as power-up |
| cmp_i | input | 1 | Asynchronous comparator bit, 1 when current ≥ trip |
| det_en_i | input | 1 | Stall detection enable |
| smode_i | input | 1 | 0: latched output disable, 1: indication only |
| rep_en_i | input | 1 | Report the stall on `fault_n_o` |
| tinrush_i | input | 16 | Window length setting T |
| pwr_up_i | input | 1 | Power-up event strobe |
| flt_rec_i | input | 1 | Fault-recovery event strobe |
| slp_exit_i | input | 1 | Sleep-exit event strobe |
| clr_flt_i | input | 1 | Clear-fault strobe |
| stall_o | output | 1 | Stall flag |
| out_dis_o | output | 1 | Request to disable the bridge outputs |
| fault_n_o | output | 1 | Active-low fault indication |
| blank_o | output | 1 | 1 while the blanking window runs |

## Verification
The bench builds the block with OFF_CYC = 6 and STEP_CYC = 4. With these values a complete window, from the offset-only case up to a few dozen cycles, fits into a short run. Windows can therefore be restarted mid-step and clears can be timed against the exact qualification cycle. A bench reference model counts the remaining window cycles for each setting. The full 16-bit range at the default clock parameters is far beyond the run length, so it is covered only through the formula that R2 checks at small T.

// File: rtl/stall_pkg.sv
package stall_pkg;

    localparam int unsigned TIN_W = 16;

    typedef enum logic [1:0] {
        BLK_OFFSET = 2'd0,
        BLK_STEPS  = 2'd1,
        BLK_IDLE   = 2'd2
    } blank_phase_e;

    typedef struct packed {
        logic stall;
        logic dis;
    } stall_state_t;

    typedef struct packed {
        logic pwr_up;
        logic flt_rec;
        logic slp_exit;
        logic clr;
    } restart_ev_t;

    function automatic logic any_restart(input restart_ev_t ev);
        return ev.pwr_up | ev.flt_rec | ev.slp_exit | ev.clr;
    endfunction

    function automatic logic report_low(input logic stall, input logic rep_en);
        return stall & rep_en;
    endfunction

endpackage

// File: rtl/stall_sync.sv
module stall_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/stall_blank_timer.sv
module stall_blank_timer
    import stall_pkg::*;
#(
    parameter int unsigned OFF_CYC  = 500000,
    parameter int unsigned STEP_CYC = 10240
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic [TIN_W-1:0] tin_i,
    output logic             blank_o
);
    localparam int unsigned OFF_W  = $clog2(OFF_CYC + 1);
    localparam int unsigned STEP_W = $clog2(STEP_CYC + 1);
    localparam logic [OFF_W-1:0]  OFF_LAST  = OFF_W'(OFF_CYC - 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_CYC - 1);

    blank_phase_e      phase_q;
    logic [OFF_W-1:0]  off_cnt_q;
    logic [STEP_W-1:0] pre_cnt_q;
    logic [TIN_W-1:0]  step_cnt_q;
    logic [TIN_W-1:0]  tin_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            phase_q    <= BLK_OFFSET;
            off_cnt_q  <= '0;
            pre_cnt_q  <= '0;
            step_cnt_q <= '0;
            tin_q      <= tin_i;
        end else begin
            case (phase_q)
                BLK_OFFSET: begin
                    if (off_cnt_q == OFF_LAST) begin
                        phase_q <= (tin_q == '0) ? BLK_IDLE : BLK_STEPS;
                    end else begin
                        off_cnt_q <= off_cnt_q + 1'b1;
                    end
                end
                BLK_STEPS: begin
                    if (pre_cnt_q == STEP_LAST) begin
                        pre_cnt_q  <= '0;
                        step_cnt_q <= step_cnt_q + 1'b1;
                        if (step_cnt_q == tin_q - TIN_W'(1)) phase_q <= BLK_IDLE;
                    end else begin
                        pre_cnt_q <= pre_cnt_q + 1'b1;
                    end
                end
                default: phase_q <= BLK_IDLE;
            endcase
        end
    end

    assign blank_o = (phase_q != BLK_IDLE);

    // R3: any restart event reopens the window on the next cycle
    p_restart_blank_r3: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> blank_o);

    // R2: once closed, the window stays closed until a restart
    p_idle_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (!blank_o && !restart_i) |=> !blank_o);

    // R2: the step phase is only entered from the offset phase
    p_steps_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == BLK_IDLE && !restart_i) |=> phase_q != BLK_STEPS);
endmodule

// File: rtl/stall_ctrl.sv
module stall_ctrl
    import stall_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         smode_i,
    input  logic         cmp_i,
    input  logic         blank_i,
    input  logic         clr_i,
    output stall_state_t st_o
);
    stall_state_t st_q;
    logic         qualify;

    assign qualify = en_i && !blank_i && cmp_i && !st_q.stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (clr_i) begin
            st_q <= '0;
        end else if (qualify) begin
            st_q.stall <= 1'b1;
            st_q.dis   <= !smode_i;
        end
    end

    assign st_o = st_q;

    // R4: a disabled detector never raises the flag
    p_off_no_set_r4: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !st_q.stall) |=> !st_q.stall);

    // R10: no flag is raised inside the window
    p_blank_no_set_r10: assert property (@(posedge clk) disable iff (rst)
        (blank_i && !st_q.stall) |=> !st_q.stall);

    // R5: the disable request is held until a clear
    p_dis_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.dis && !clr_i) |=> st_q.dis);

    // R5: a disable request never exists without the flag
    p_dis_needs_stall_r5: assert property (@(posedge clk) disable iff (rst)
        st_q.dis |-> st_q.stall);

    // R6: indication-only mode never raises the disable request
    p_mode1_no_dis_r6: assert property (@(posedge clk) disable iff (rst)
        (!st_q.dis && smode_i) |=> !st_q.dis);

    // R7 R9: a clear always wins
    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (!st_q.stall && !st_q.dis));
endmodule

// File: rtl/stall_detector.sv
module stall_detector
    import stall_pkg::*;
#(
    parameter int unsigned OFF_CYC   = 500000,
    parameter int unsigned STEP_CYC  = 10240,
    parameter int unsigned SYNC_STGS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmp_i,
    input  logic        det_en_i,
    input  logic        smode_i,
    input  logic        rep_en_i,
    input  logic [15:0] tinrush_i,
    input  logic        pwr_up_i,
    input  logic        flt_rec_i,
    input  logic        slp_exit_i,
    input  logic        clr_flt_i,
    output logic        stall_o,
    output logic        out_dis_o,
    output logic        fault_n_o,
    output logic        blank_o
);
    logic         cmp_s;
    logic         blank;
    logic         restart;
    restart_ev_t  ev;
    stall_state_t st;

    assign ev.pwr_up   = pwr_up_i;
    assign ev.flt_rec  = flt_rec_i;
    assign ev.slp_exit = slp_exit_i;
    assign ev.clr      = clr_flt_i;
    assign restart     = any_restart(ev);

    stall_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cmp_i),
        .q_o (cmp_s)
    );

    stall_blank_timer #(.OFF_CYC(OFF_CYC), .STEP_CYC(STEP_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .tin_i     (tinrush_i),
        .blank_o   (blank)
    );

    stall_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .en_i    (det_en_i),
        .smode_i (smode_i),
        .cmp_i   (cmp_s),
        .blank_i (blank),
        .clr_i   (clr_flt_i),
        .st_o    (st)
    );

    assign stall_o   = st.stall;
    assign out_dis_o = st.dis;
    assign fault_n_o = !report_low(st.stall, rep_en_i);
    assign blank_o   = blank;

    // R8: with reporting off the fault pin stays high
    p_no_report_r8: assert property (@(posedge clk) disable iff (rst)
        !rep_en_i |-> fault_n_o);

    // R8: a low fault pin always means a flagged stall
    p_fault_means_stall_r8: assert property (@(posedge clk) disable iff (rst)
        !fault_n_o |-> stall_o);
endmodule

// File: tb/stall_detector_test.sv
module stall_detector_test;
    localparam int OFF  = 6;
    localparam int STEP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp = 1'b0, en = 1'b0, smode = 1'b0, rep = 1'b0;
    logic [15:0] tin = 16'd2;
    logic        pwr = 1'b0, frec = 1'b0, sexit = 1'b0, clr = 1'b0;
    logic        stall_o, dis_o, fault_n_o, blank_o;

    int  n_checks = 0, n_errors = 0;
    bit  done = 1'b0, checking = 1'b0;
    string tag = "R3";

    // reference state
    logic r_s1 = 1'b0, r_s2 = 1'b0, r_stall = 1'b0, r_dis = 1'b0;
    int   r_rem = 0;

    always #2.5 clk = ~clk;

    stall_detector #(.OFF_CYC(OFF), .STEP_CYC(STEP)) uut (
        .clk(clk), .rst(rst), .cmp_i(cmp), .det_en_i(en), .smode_i(smode),
        .rep_en_i(rep), .tinrush_i(tin), .pwr_up_i(pwr), .flt_rec_i(frec),
        .slp_exit_i(sexit), .clr_flt_i(clr), .stall_o(stall_o),
        .out_dis_o(dis_o), .fault_n_o(fault_n_o), .blank_o(blank_o));

    function automatic int win_len(input logic [15:0] t);
        return OFF + int'(t) * STEP;
    endfunction

    always @(posedge clk) begin
        logic qual;
        qual = en && (r_rem == 0) && r_s2 && !r_stall;
        if (rst) begin
            r_s1 <= 1'b0; r_s2 <= 1'b0; r_stall <= 1'b0; r_dis <= 1'b0;
            r_rem <= win_len(tin);
        end else begin
            r_s1 <= cmp; r_s2 <= r_s1;
            if (clr) begin
                r_stall <= 1'b0; r_dis <= 1'b0;
            end else if (qual) begin
                r_stall <= 1'b1; r_dis <= !smode;
            end
            if (pwr || frec || sexit || clr) r_rem <= win_len(tin);
            else if (r_rem > 0)              r_rem <= r_rem - 1;
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // sample at negedge, then inputs may change
    task automatic tick();
        @(negedge clk);
        if (checking) begin
            chk("stall", stall_o, r_stall);
            chk("out_dis", dis_o, r_dis);
            chk("fault_n", fault_n_o, !(r_stall && rep));
            chk("blank", blank_o, r_rem != 0);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic pulse_clr();
        clr = 1'b1; tick(); clr = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R3: reset acts as power-up and opens a window
        tag = "R3";
        run(3);
        checking = 1'b1;
        rst = 1'b0;
        tick();
        chk("blank after reset R3", blank_o, 1'b1);
        run(win_len(16'd2) + 2);
        chk("blank closed R2", blank_o, 1'b0);

        // R1: exact latency outside the window
        tag = "R1";
        en = 1'b1; rep = 1'b1; smode = 1'b0;
        cmp = 1'b1;
        tick(); chk("no flag after 1 edge R1", stall_o, 1'b0);
        tick(); chk("no flag after 2 edges R1", stall_o, 1'b0);
        tick(); chk("flag after 3 edges R1", stall_o, 1'b1);
        tag = "R5";
        chk("latched disable R5", dis_o, 1'b1);
        tag = "R8";
        chk("fault pin low R8", fault_n_o, 1'b0);
        tag = "R5";
        run(10);
        chk("disable held R5", dis_o, 1'b1);

        // R7: clear with current still high, redetect after window T=3
        tag = "R7";
        tin = 16'd3;
        pulse_clr();
        chk("flag cleared R7", stall_o, 1'b0);
        chk("disable cleared R7", dis_o, 1'b0);
        tag = "R10";
        run(win_len(16'd3) - 1);
        chk("no flag inside window R10", stall_o, 1'b0);
        tag = "R2";
        run(2);
        chk("redetect after window R2", stall_o, 1'b1);

        // R6: indication only
        tag = "R6";
        smode = 1'b1; tin = 16'd0;
        pulse_clr();
        run(win_len(16'd0) + 3);
        chk("flag in mode 1 R6", stall_o, 1'b1);
        chk("no disable in mode 1 R6", dis_o, 1'b0);

        // R8: reporting off
        tag = "R8";
        rep = 1'b0; tick();
        chk("fault pin high with report off R8", fault_n_o, 1'b1);
        rep = 1'b1;

        // R4: detection disabled
        tag = "R4";
        en = 1'b0; smode = 1'b0;
        pulse_clr();
        run(win_len(16'd0) + 20);
        chk("no flag when disabled R4", stall_o, 1'b0);
        chk("no disable when disabled R4", dis_o, 1'b0);
        en = 1'b1;

        // R3: each event strobe restarts a running window
        tag = "R3";
        tin = 16'd2;
        pulse_clr(); run(5);
        pwr = 1'b1; tick(); pwr = 1'b0; run(7);
        frec = 1'b1; tick(); frec = 1'b0; run(9);
        sexit = 1'b1; tick(); sexit = 1'b0;
        chk("window open after sleep exit R3", blank_o, 1'b1);
        run(win_len(16'd2) + 3);

        // R9: clear in the qualification cycle
        tag = "R9";
        pulse_clr();
        while (!(r_rem == 0 && r_s2 && !r_stall && en)) tick();
        clr = 1'b1; tick(); clr = 1'b0;
        chk("clear wins R9", stall_o, 1'b0);
        chk("window restarted R9", blank_o, 1'b1);
        run(win_len(16'd2) + 3);

        // R1: random mix
        tag = "R1 random";
        for (int i = 0; i < 6000; i++) begin
            cmp   = ($urandom % 8) < 5;
            if ($urandom % 40 == 0) en    = $urandom % 4 != 0;
            if ($urandom % 40 == 0) smode = $urandom % 2;
            if ($urandom % 30 == 0) rep   = $urandom % 2;
            if ($urandom % 25 == 0) tin   = 16'($urandom % 7);
            pwr   = ($urandom % 150) == 0;
            frec  = ($urandom % 150) == 0;
            sexit = ($urandom % 150) == 0;
            clr   = ($urandom % 60) == 0;
            tick();
        end
        pwr = 1'b0; frec = 1'b0; sexit = 1'b0; clr = 1'b0;
        run(4);

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule